// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block sits on the byte-wide read path of a NOR-style flash model. While the command sequencer reports that an internal program, sector erase or chip erase is running, or that an erase has been suspended, reads no longer return array contents. They return a status byte instead. That byte carries a polling bit, a per-read toggling bit, a time-limit bit and a sector-scoped toggling bit, and every other bit position is zero. When no operation is active, the array byte passes through unchanged.

Read requests arrive on a valid/ready channel with an address. Results leave on a second valid/ready channel through a single response register. A request is accepted when `rd_valid && rd_ready`. `rd_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held, and so no new request is taken. The status byte is formed from the sequencer state present in the accept cycle.

The two toggling bits are internal flip-flops. They advance once per accepted read that they apply to. They are cleared by a one-cycle `op_start` pulse, which the sequencer issues when a new operation begins.

Top module: `flash_status_mux`

## Requirements
- R1: With `op_busy`=0 and `op_susp`=0, an accepted read returns `arr_data` as it was in the accept cycle.
- R2: Program mode applies when `op_busy`=1 and `op_kind`=2'b00. In this mode a read returns bit7 = NOT `prog_bit7`, bit6 = program toggle, bit5 = `op_timeout` and bit2 = 1. Bits 4, 3, 1 and 0 are 0.
- R3: Erase mode applies when `op_busy`=1, `op_susp`=0 and `op_kind` is 2'b01 (sector) or 2'b10 (chip). A read that hits an erasing sector returns bit7 = 0, bit6 = program toggle, bit5 = `op_timeout` and bit2 = sector toggle. All other bits are 0.
- R4: The bit-6 toggle flips after every accepted read in program or erase mode, at any address. It does not move in idle or suspend-read mode.
- R5: Suspend-read mode applies when `op_susp`=1 and program mode does not apply. A read that hits a marked sector returns bit7 = 1, bit6 = 1, bit5 = 0 and bit2 = sector toggle, with all other bits 0. A read of an unmarked sector returns `arr_data`.
- R6: A program issued while `op_susp`=1 produces exactly the program-mode byte of R2.
- R7: During a sector erase, a read whose sector is not marked in `erase_map` returns 8'h00. Such a read does not advance the bit-2 toggle.
- R8: A read hits a sector when bit `rd_addr[AW-1:AW-SW]` of `erase_map` is 1. During a chip erase (`op_kind`=2'b10), every address counts as a hit, whatever `erase_map` holds.
- R9: `op_start` clears both toggles. A read accepted in the same cycle as `op_start` is the first read of the new operation, so it sees both toggles as 0.
- R10: `rd_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_valid` hold.
- R11: A read accepted in the last busy cycle returns status. A read accepted once `op_busy` has fallen returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse marking the start of a new operation |
| op_busy | input | 1 | Embedded operation running |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase |
| op_susp | input | 1 | Erase suspended |
| op_timeout | input | 1 | Operation exceeded its time limit |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| erase_map | input | 2**SW | One bit per sector, 1 = marked for erase |
| arr_data | input | 8 | Array byte at `rd_addr` |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | AW | Read byte address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read data or status byte |

## Verification
The toggle clear from `op_start` and the toggle advance from an accepted read can land in the same cycle. The bench provokes this by pulsing `op_start` together with a read, at a point where the toggles are already set from an earlier operation. It then expects that read to show both toggles at 0, and the following read to show bit 6 at 1. The same traffic also runs while the response channel is stalled, so a toggle advance and a held response overlap. The scoreboard compares the bytes in order, and a separate check confirms that a stalled response does not change.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [1:0] {
    OP_PROG        = 2'b00,
    OP_SECT_ERASE  = 2'b01,
    OP_CHIP_ERASE  = 2'b10
  } op_kind_e;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_PROG  = 2'd1,
    M_ERASE = 2'd2,
    M_SUSP  = 2'd3
  } stat_mode_e;

  function automatic stat_mode_e pick_mode(input logic busy, input logic [1:0] kind,
                                           input logic susp);
    stat_mode_e m;
    if (busy && kind == OP_PROG)  m = M_PROG;
    else if (susp)                m = M_SUSP;
    else if (busy)                m = M_ERASE;
    else                          m = M_IDLE;
    return m;
  endfunction

endpackage

// File: rtl/flash_sect_hit.sv
module flash_sect_hit #(
  parameter int AW = 12,
  parameter int SW = 3
) (
  input  logic [AW-1:0]      rd_addr,
  input  logic [(1<<SW)-1:0] erase_map,
  input  logic               chip_all,
  output logic               hit
);
  localparam int NSECT = 1 << SW;

  logic [SW-1:0] sect_idx;
  logic [NSECT-1:0] sel;

  assign sect_idx = rd_addr[AW-1 -: SW];

  for (genvar g = 0; g < NSECT; g++) begin : g_sel
    assign sel[g] = (sect_idx == SW'(g)) && erase_map[g];
  end

  assign hit = chip_all || (|sel);
endmodule

// File: rtl/flash_flag_toggles.sv
module flash_flag_toggles (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic adv6,
  input  logic adv2,
  output logic eff6,
  output logic eff2
);
  logic q6, q2;

  assign eff6 = op_start ? 1'b0 : q6;
  assign eff2 = op_start ? 1'b0 : q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q6 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q6 <= eff6 ^ adv6;
      q2 <= eff2 ^ adv2;
    end
  end

  // R4: each counted read flips the bit-6 toggle
  p_tog6_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv6 && !op_start |=> q6 != $past(q6));

  // R9: a start with no read leaves both toggles cleared
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && !adv6 && !adv2 |=> !q6 && !q2);

  // R9: a start with a counted read leaves bit-6 toggle at one
  p_start_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && adv6 |=> q6);
endmodule

// File: rtl/flash_stat_compose.sv
module flash_stat_compose
  import flash_stat_pkg::*;
(
  input  stat_mode_e  mode,
  input  logic        hit,
  input  logic        prog_bit7,
  input  logic        timeout,
  input  logic        eff6,
  input  logic        eff2,
  input  logic [7:0]  arr_data,
  output logic [7:0]  byte_out
);
  always_comb begin
    byte_out = 8'h00;
    unique case (mode)
      M_IDLE:  byte_out = arr_data;
      M_PROG:  byte_out = {~prog_bit7, eff6, timeout, 2'b00, 1'b1, 2'b00};
      M_ERASE: byte_out = hit ? {1'b0, eff6, timeout, 2'b00, eff2, 2'b00} : 8'h00;
      M_SUSP:  byte_out = hit ? {1'b1, 1'b1, 1'b0, 2'b00, eff2, 2'b00} : arr_data;
      default: byte_out = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_stat_pkg::*;
#(
  parameter int AW = 12,
  parameter int SW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_start,
  input  logic               op_busy,
  input  logic [1:0]         op_kind,
  input  logic               op_susp,
  input  logic               op_timeout,
  input  logic               prog_bit7,
  input  logic [(1<<SW)-1:0] erase_map,
  input  logic [7:0]         arr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [AW-1:0]      rd_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_data
);
  stat_mode_e mode;
  logic accept, hit, chip_all, eff6, eff2, adv6, adv2;
  logic [7:0] next_byte;

  assign mode     = pick_mode(op_busy, op_kind, op_susp);
  assign chip_all = (op_kind == OP_CHIP_ERASE);
  assign rd_ready = !rsp_valid || rsp_ready;
  assign accept   = rd_valid && rd_ready;
  assign adv6     = accept && (mode == M_PROG || mode == M_ERASE);
  assign adv2     = accept && hit && (mode == M_ERASE || mode == M_SUSP);

  flash_sect_hit #(.AW(AW), .SW(SW)) u_hit (
    .rd_addr(rd_addr), .erase_map(erase_map), .chip_all(chip_all), .hit(hit)
  );

  flash_flag_toggles u_tog (
    .clk(clk), .rst_n(rst_n), .op_start(op_start),
    .adv6(adv6), .adv2(adv2), .eff6(eff6), .eff2(eff2)
  );

  flash_stat_compose u_cmp (
    .mode(mode), .hit(hit), .prog_bit7(prog_bit7), .timeout(op_timeout),
    .eff6(eff6), .eff2(eff2), .arr_data(arr_data), .byte_out(next_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= next_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1: idle reads pass the array byte
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !op_busy && !op_susp |=> rsp_data == $past(arr_data));

  // R2: program polling bit is the inverse of the written bit
  p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_busy && op_kind == 2'b00 |=> rsp_data[7] != $past(prog_bit7));

  // R7: unmarked sector during sector erase reads zero
  p_outside_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_busy && !op_susp && op_kind == 2'b01 && !erase_map[rd_addr[AW-1 -: SW]]
    |=> rsp_data == 8'h00);

  // R10: a stalled response holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10: an accepted request always yields a response next cycle
  p_accept_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rsp_valid);
endmodule

// File: tb/flash_status_mux_bench.sv
module flash_status_mux_bench;
  localparam int AW = 12;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 1'b0, op_busy = 1'b0, op_susp = 1'b0, op_timeout = 1'b0;
  logic prog_bit7 = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [7:0] erase_map = 8'h00;
  logic [7:0] arr_data;
  logic rd_valid = 1'b0, rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int n_chk = 0, n_fail = 0;
  bit bp_on = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic m6 = 1'b0, m2 = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] arr_fn(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {4'h0, a[11:8]};
  endfunction
  assign arr_data = arr_fn(rd_addr);

  flash_status_mux #(.AW(AW), .SW(SW)) u_flash_status_mux (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_busy(op_busy),
    .op_kind(op_kind), .op_susp(op_susp), .op_timeout(op_timeout),
    .prog_bit7(prog_bit7), .erase_map(erase_map), .arr_data(arr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // consumer back-pressure, changed just after each rising edge
  initial begin
    int k;
    k = 0;
    forever begin
      @(posedge clk);
      #1;
      k++;
      rsp_ready = bp_on ? ((k % 3) == 0) : 1'b1;
    end
  end

  // monitor: pops the scoreboard on each response handshake
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && rsp_valid)
        check(rsp_data == prev_data, "R10 hold", rsp_data, prev_data);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", rsp_data, 8'h00);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_data  = rsp_data;
    end
  end

  // driver: issues one read and pushes its expected byte
  task automatic do_read(input logic [AW-1:0] a, input bit start, input string tag);
    logic hit, e6, e2;
    logic [7:0] e;
    int mode;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_addr  = a;
    rd_valid = 1'b1;
    op_start = start;
    hit = (op_kind == 2'b10) || erase_map[a[AW-1 -: SW]];
    e6 = start ? 1'b0 : m6;
    e2 = start ? 1'b0 : m2;
    if (op_busy && op_kind == 2'b00) mode = 1;
    else if (op_susp)                mode = 3;
    else if (op_busy)                mode = 2;
    else                             mode = 0;
    case (mode)
      1: e = {~prog_bit7, e6, op_timeout, 2'b00, 1'b1, 2'b00};
      2: e = hit ? {1'b0, e6, op_timeout, 2'b00, e2, 2'b00} : 8'h00;
      3: e = hit ? 8'hC0 | {5'b0, e2, 2'b00} : arr_fn(a);
      default: e = arr_fn(a);
    endcase
    m6 = e6 ^ (mode == 1 || mode == 2);
    m2 = e2 ^ (hit && (mode == 2 || mode == 3));
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_valid = 1'b0;
    op_start = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || rsp_valid) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    #40000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R10 reset valid", {7'b0, rsp_valid}, 8'h00);
    check(rd_ready == 1'b1, "R10 reset ready", {7'b0, rd_ready}, 8'h01);
    rst_n = 1'b1;

    // R1 idle passthrough
    do_read(12'h012, 0, "R1 idle");
    do_read(12'h7A3, 0, "R1 idle");
    do_read(12'hFFF, 0, "R1 idle");

    // R2/R4/R9 program, first read with start
    op_busy = 1'b1; op_kind = 2'b00; prog_bit7 = 1'b0;
    do_read(12'h100, 1, "R9 program start");
    do_read(12'h100, 0, "R4 program toggle");
    do_read(12'h900, 0, "R2 program");
    op_timeout = 1'b1;
    do_read(12'h100, 0, "R2 timeout");
    op_timeout = 1'b0;
    prog_bit7 = 1'b1;
    do_read(12'h100, 0, "R2 program bit7 set");
    // R11 last busy read then data
    do_read(12'h100, 0, "R11 last status");
    op_busy = 1'b0;
    do_read(12'h100, 0, "R11 data after done");
    do_read(12'h101, 0, "R4 idle no toggle");

    // sector erase with back-pressure, R3/R7/R9
    bp_on = 1'b1;
    erase_map = 8'b0000_0100;
    op_busy = 1'b1; op_kind = 2'b01;
    do_read(12'h410, 0, "R3 erase hit before start");
    do_read(12'h420, 1, "R9 start with read");
    do_read(12'h430, 0, "R3 erase hit");
    do_read(12'h030, 0, "R7 outside zero");
    do_read(12'h5FF, 0, "R3 erase hit toggle");
    op_timeout = 1'b1;
    do_read(12'h400, 0, "R3 erase timeout");
    op_timeout = 1'b0;
    do_read(12'hE00, 0, "R7 outside zero");
    bp_on = 1'b0;

    // R5 suspend read
    op_busy = 1'b0; op_susp = 1'b1;
    do_read(12'h440, 0, "R5 suspend hit");
    do_read(12'h441, 0, "R5 suspend hit toggle");
    do_read(12'h240, 0, "R5 suspend unmarked");
    do_read(12'h441, 0, "R4 suspend no bit6 move");

    // R6 program during suspend
    op_busy = 1'b1; op_kind = 2'b00; prog_bit7 = 1'b1;
    do_read(12'h240, 0, "R6 suspend program");
    do_read(12'h440, 0, "R6 suspend program");
    op_busy = 1'b0; op_kind = 2'b01;
    do_read(12'h450, 0, "R5 back to suspend read");
    op_susp = 1'b0;

    // R8 chip erase ignores map
    erase_map = 8'h00;
    op_busy = 1'b1; op_kind = 2'b10;
    do_read(12'h000, 1, "R8 chip erase start");
    do_read(12'hC55, 0, "R8 chip erase any sector");
    do_read(12'h6AA, 0, "R8 chip erase toggle");
    do_read(12'h123, 1, "R9 restart mid-op");
    op_busy = 1'b0;
    do_read(12'h123, 0, "R1 idle after chip erase");

    drain();
    check(exp_q.size() == 0, "R10 all responses returned", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule